// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block is a one-byte channel through which a processor hands data to an on-chip debugger. When the processor stores a byte at the mailbox address, the block keeps the byte and raises a pending flag. The debugger can then tell that fresh data is waiting. When the processor reads the mailbox back, it sees the low seven stored bits, with the pending flag in place of the top bit. The debugger takes the whole byte through its own read strobe, and that read lowers the flag.

The mailbox address is shared with an ordinary 8-bit I/O register held in the same block. The processor reaches the mailbox only when two conditions hold: the debug-enable fuse input reads as programmed, and the debugger has granted mailbox access. Otherwise every processor read and write at that address goes to the I/O register. The fuse storage and the debug transport that carries the byte off chip belong to other blocks.

Top module: `dbg_mailbox`

## Requirements
- R1: A synchronous active-high `rst` clears the stored mailbox byte, the pending flag and the I/O register, so all three read as zero after reset.
- R2: A processor write (`cpu_we`) at `MBOX_ADDR` that is routed to the mailbox stores `cpu_wdata` and sets `dbg_dirty` at the same clock edge. Both are visible in the following cycle.
- R3: A processor read (`cpu_re`) routed to the mailbox returns, in the same cycle, stored bits 6:0 on `cpu_rdata[6:0]` and the pending flag on `cpu_rdata[7]`.
- R4: While `dbg_rd` is high, `dbg_rdata` carries all eight stored bits in the same cycle. The pending flag is clear after that clock edge. While `dbg_rd` is low, `dbg_rdata` is zero.
- R5: If a routed processor write and `dbg_rd` occur in the same cycle, the write wins: the new byte is stored and `dbg_dirty` stays 1. During that cycle, `dbg_rdata` still shows the old byte.
- R6: A processor read never changes `dbg_dirty`. Only routed processor writes set it, and only `dbg_rd` clears it.
- R7: Processor accesses at `MBOX_ADDR` reach the mailbox only when `fuse_prog` and `dbg_grant` are both 1. In the other three combinations they reach the I/O register, and the mailbox byte and flag are left unchanged.
- R8: The I/O register is a plain 8-bit read/write register. A read returns all eight bits exactly as last written, with no flag substitution.
- R9: When `cpu_re` is low or `cpu_addr` differs from `MBOX_ADDR`, `cpu_rdata` is zero. A write to any other address changes neither the mailbox, the flag nor the I/O register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | Processor I/O address |
| cpu_we | input | 1 | Processor write strobe |
| cpu_re | input | 1 | Processor read strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, combinational |
| fuse_prog | input | 1 | Debug-enable fuse state, 1 = programmed |
| dbg_grant | input | 1 | Debugger grants processor access to the mailbox |
| dbg_rd | input | 1 | Debugger read strobe; clears the pending flag |
| dbg_rdata | output | 8 | Full stored byte while `dbg_rd` is high, else zero |
| dbg_dirty | output | 1 | Pending flag: unread mailbox data is waiting |

## Verification
The assertions assume that `fuse_prog` and `dbg_grant` are steady across each clock edge at which they act. They also assume that `cpu_we` and `cpu_re` are never both high in one cycle. Under that assumption, a cycle's read result is never mixed up with its own write.

The stimulus changes every input only at the falling clock edge. It never raises both processor strobes together. It walks the fuse and grant pair through all four values, writing and reading between changes. Collision cycles pair a debugger read with a single processor write only.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;

    localparam int MB_W    = 8;
    localparam int FLAG_IX = MB_W - 1;

    typedef struct packed {
        logic [MB_W-1:0] byte_v;
        logic            dirty;
    } mbox_st_t;

    typedef struct packed {
        logic mbox_wr;
        logic mbox_rd;
        logic io_wr;
        logic io_rd;
    } route_t;

endpackage

// File: rtl/dbg_mbox_route.sv
module dbg_mbox_route
    import dbg_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic              fuse_prog,
    input  logic              dbg_grant,
    output route_t            sel
);
    logic hit;
    logic to_mbox;

    always_comb begin
        hit         = (cpu_addr == MBOX_ADDR);
        to_mbox     = fuse_prog & dbg_grant;
        sel.mbox_wr = hit & cpu_we &  to_mbox;
        sel.mbox_rd = hit & cpu_re &  to_mbox;
        sel.io_wr   = hit & cpu_we & ~to_mbox;
        sel.io_rd   = hit & cpu_re & ~to_mbox;
    end
endmodule

// File: rtl/dbg_mbox_store.sv
module dbg_mbox_store
    import dbg_mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [MB_W-1:0] wdata,
    input  logic            dbg_rd,
    output logic [MB_W-1:0] data_q,
    output logic            dirty_q
);
    mbox_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.byte_v = wdata;
            st_d.dirty  = 1'b1;
        end else if (dbg_rd) begin
            st_d.dirty  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_q  = st_q.byte_v;
    assign dirty_q = st_q.dirty;
endmodule

// File: rtl/dbg_mbox_ioreg.sv
module dbg_mbox_ioreg
    import dbg_mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [MB_W-1:0] wdata,
    output logic [MB_W-1:0] data_q
);
    logic [MB_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr) reg_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= reg_d;
    end

    assign data_q = reg_q;
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              fuse_prog,
    input  logic              dbg_grant,
    input  logic              dbg_rd,
    output logic [7:0]        dbg_rdata,
    output logic              dbg_dirty
);
    route_t          sel;
    logic [MB_W-1:0] mb_q;
    logic            mb_dirty;
    logic [MB_W-1:0] io_q;

    dbg_mbox_route #(.ADDR_W(ADDR_W), .MBOX_ADDR(MBOX_ADDR)) u_route (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .cpu_re   (cpu_re),
        .fuse_prog(fuse_prog),
        .dbg_grant(dbg_grant),
        .sel      (sel)
    );

    dbg_mbox_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (sel.mbox_wr),
        .wdata  (cpu_wdata),
        .dbg_rd (dbg_rd),
        .data_q (mb_q),
        .dirty_q(mb_dirty)
    );

    dbg_mbox_ioreg u_io (
        .clk   (clk),
        .rst   (rst),
        .wr    (sel.io_wr),
        .wdata (cpu_wdata),
        .data_q(io_q)
    );

    // Processor read path: mailbox view swaps in the pending flag on top.
    always_comb begin
        cpu_rdata = '0;
        if (sel.mbox_rd)
            cpu_rdata = {mb_dirty, mb_q[FLAG_IX-1:0]};
        else if (sel.io_rd)
            cpu_rdata = io_q;
    end

    assign dbg_rdata = dbg_rd ? mb_q : '0;
    assign dbg_dirty = mb_dirty;
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_we,
    input logic              cpu_re,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        cpu_rdata,
    input logic              fuse_prog,
    input logic              dbg_grant,
    input logic              dbg_rd,
    input logic [7:0]        dbg_rdata,
    input logic              dbg_dirty
);
    logic mb_wr_c, mb_rd_c;
    assign mb_wr_c = cpu_we && (cpu_addr == MBOX_ADDR) && fuse_prog && dbg_grant;
    assign mb_rd_c = cpu_re && (cpu_addr == MBOX_ADDR) && fuse_prog && dbg_grant;

    // R2
    write_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        mb_wr_c |=> dbg_dirty);

    // R2
    write_stores_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (mb_wr_c && !cpu_re) ##1 dbg_rd |-> dbg_rdata == $past(cpu_wdata));

    // R3
    read_flag_bit_chk: assert property (@(posedge clk) disable iff (rst)
        mb_rd_c |-> cpu_rdata[7] == dbg_dirty);

    // R4
    dbg_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd && !mb_wr_c) |=> !dbg_dirty);

    // R4
    dbg_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dbg_rd |-> dbg_rdata == 8'h00);

    // R6
    flag_no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!dbg_dirty && !mb_wr_c) |=> !dbg_dirty);

    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_dirty && !dbg_rd) |=> dbg_dirty);

    // R9
    miss_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_re || cpu_addr != MBOX_ADDR) |-> cpu_rdata == 8'h00);
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.ADDR_W(ADDR_W), .MBOX_ADDR(MBOX_ADDR)) u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fuse_prog(fuse_prog),
    .dbg_grant(dbg_grant), .dbg_rd(dbg_rd), .dbg_rdata(dbg_rdata), .dbg_dirty(dbg_dirty)
);

// File: tb/dbg_mailbox_test.sv
`timescale 1ns/1ps
module dbg_mailbox_test;
    localparam logic [5:0] MA = 6'h31;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] cpu_addr;
    logic       cpu_we, cpu_re, fuse_prog, dbg_grant, dbg_rd;
    logic [7:0] cpu_wdata, cpu_rdata, dbg_rdata;
    logic       dbg_dirty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    int m_byte, m_io, m_dirty;

    always #2.5 clk = ~clk;

    dbg_mailbox uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fuse_prog(fuse_prog),
        .dbg_grant(dbg_grant), .dbg_rd(dbg_rd), .dbg_rdata(dbg_rdata), .dbg_dirty(dbg_dirty)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare outputs, then advance the model.
    task automatic cyc(string req, logic [5:0] a, bit we, bit re, logic [7:0] wd,
                       bit fu, bit gr, bit dr);
        int e_cpu, e_dbg;
        bit hit, to_mb;
        @(negedge clk);
        cpu_addr = a; cpu_we = we; cpu_re = re; cpu_wdata = wd;
        fuse_prog = fu; dbg_grant = gr; dbg_rd = dr;
        #1;
        hit   = (a == MA);
        to_mb = fu && gr;
        e_cpu = 0;
        if (re && hit) e_cpu = to_mb ? ((m_dirty << 7) | (m_byte & 8'h7f)) : m_io;
        e_dbg = dr ? m_byte : 0;
        check(req, "cpu_rdata", int'(cpu_rdata), e_cpu);
        check(req, "dbg_rdata", int'(dbg_rdata), e_dbg);
        check(req, "dbg_dirty", int'(dbg_dirty), m_dirty);
        @(posedge clk);
        if (we && hit && to_mb) begin m_byte = wd; m_dirty = 1; end
        else if (dr) m_dirty = 0;
        if (we && hit && !to_mb) m_io = wd;
    endtask

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_we = 0; cpu_re = 0; cpu_wdata = '0;
        fuse_prog = 0; dbg_grant = 0; dbg_rd = 0;
        m_byte = 0; m_io = 0; m_dirty = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state on both targets
        cyc("R1", MA, 0, 1, 8'h00, 1, 1, 0);
        cyc("R1", MA, 0, 1, 8'h00, 0, 0, 0);
        cyc("R1", MA, 0, 0, 8'h00, 1, 1, 1);
        // R2 / R3 write then read with flag substitution
        cyc("R2", MA, 1, 0, 8'h25, 1, 1, 0);
        cyc("R3", MA, 0, 1, 8'h00, 1, 1, 0);
        cyc("R2", MA, 1, 0, 8'h3c, 1, 1, 0);
        cyc("R3", MA, 0, 1, 8'h00, 1, 1, 0);
        // R6 repeated reads keep the flag
        cyc("R6", MA, 0, 1, 8'h00, 1, 1, 0);
        cyc("R6", MA, 0, 1, 8'h00, 1, 1, 0);
        // R4 debugger read then flag gone
        cyc("R4", MA, 0, 0, 8'h00, 1, 1, 1);
        cyc("R4", MA, 0, 1, 8'h00, 1, 1, 0);
        cyc("R6", MA, 0, 1, 8'h00, 1, 1, 0);
        // R3 byte with top bit set, flag then cleared
        cyc("R3", MA, 1, 0, 8'hf0, 1, 1, 0);
        cyc("R4", MA, 0, 0, 8'h00, 1, 1, 1);
        cyc("R3", MA, 0, 1, 8'h00, 1, 1, 0);
        // R5 collision
        cyc("R5", MA, 1, 0, 8'h81, 1, 1, 1);
        cyc("R5", MA, 0, 1, 8'h00, 1, 1, 0);
        cyc("R5", MA, 0, 0, 8'h00, 1, 1, 1);
        // R7 all four fuse/grant combinations
        for (int k = 0; k < 4; k++) begin
            cyc("R7", MA, 1, 0, 8'h10 + 8'(k * 17), k[1], k[0], 0);
            cyc("R7", MA, 0, 1, 8'h00, k[1], k[0], 0);
            cyc("R7", MA, 0, 1, 8'h00, 1, 1, 0);
            cyc("R7", MA, 0, 1, 8'h00, 0, 0, 0);
        end
        cyc("R4", MA, 0, 0, 8'h00, 0, 1, 1);
        // R8 full-width I/O register
        cyc("R8", MA, 1, 0, 8'hff, 1, 0, 0);
        cyc("R8", MA, 0, 1, 8'h00, 0, 1, 0);
        cyc("R8", MA, 1, 0, 8'h80, 0, 0, 0);
        cyc("R8", MA, 0, 1, 8'h00, 1, 0, 0);
        // R9 other addresses
        cyc("R9", 6'h05, 1, 0, 8'h5a, 1, 1, 0);
        cyc("R9", 6'h05, 0, 1, 8'h00, 1, 1, 0);
        cyc("R9", 6'h05, 1, 0, 8'h5a, 0, 0, 0);
        cyc("R9", MA, 0, 1, 8'h00, 1, 1, 0);
        cyc("R9", MA, 0, 1, 8'h00, 0, 0, 0);
        cyc("R9", MA, 0, 0, 8'h00, 1, 1, 0);
        // R1 reset mid-run
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        m_byte = 0; m_io = 0; m_dirty = 0;
        @(negedge clk) rst = 1'b0;
        cyc("R1", MA, 0, 1, 8'h00, 1, 1, 1);
        cyc("R1", MA, 0, 1, 8'h00, 0, 1, 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule